// File: doc/BRIEF.md
# Paged MMIO Register Front End with Storage Window

This block sits between a simple request/response bus port and a storage cache. It decodes 32-bit reads and writes that fall inside an 8 KiB MMIO region. The lower 4 KiB of the region holds a small bank of control registers. The upper 4 KiB is a data window onto a much larger backing store.

Software first writes a 29-bit page selector. The block then joins that selector with the 12-bit offset of any window access, which gives a 41-bit byte address. The access is passed to the cache port, and the bus response is held until the cache acknowledges it.

The control bank also starts a flush of the cache's dirty lines. Completion of the flush is latched in a sticky flag that software clears by writing a 1 to it.

Top module: `mmio_page_window`

## Requirements
- R1: After reset the page selector is 0, the sticky flush-done flag is 0, `flush_req` is low, `bus_req_ready` is high and `bus_rsp_valid` is low.
- R2: Offset 0x000 holds the page selector. A write updates bit i (i < 29) only when strobe byte i/8 is set. A read returns the selector in bits 28:0 and 0 in bits 31:29.
- R3: An access to base+0x1000..base+0x1FFF raises `mem_req_valid`. The request carries the address {selector, addr[11:2], 2'b00} together with the bus write flag, write data and strobes.
- R4: A window request is held stable until `mem_ack`. `bus_rsp_valid` follows one cycle after the acknowledge. `bus_rsp_rdata` is `mem_rdata` for a read and 0 for a write.
- R5: A control-region access, or an access outside the region, gets `bus_rsp_valid` in the cycle after it is accepted. `bus_req_ready` is low from acceptance until the response has been given.
- R6: Undefined control offsets, and addresses outside the 8 KiB region, read as 0. Writes to them change no register and produce no cache request.
- R7: Any write to offset 0x018 raises `flush_req` in the next cycle, whatever the data. `flush_req` stays high until `flush_done` is seen.
- R8: A write to offset 0x018 while `flush_req` is high is ignored. `flush_req` falls after `flush_done` and does not rise again.
- R9: Offset 0x01C reads the sticky flush-done flag in bit 0. `flush_done` sets the flag and repeated reads leave it set.
- R10: A write to offset 0x020 clears the flag only when wdata bit 0 and strobe bit 0 are both 1. Any other write there leaves the flag unchanged.
- R11: When `flush_done` arrives in the same cycle as a clearing write to 0x020, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_valid | input | 1 | Bus request present |
| bus_req_ready | output | 1 | Block can accept a request |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | 32 | Byte address |
| bus_req_wdata | input | 32 | Write data |
| bus_req_strb | input | 4 | Byte strobes |
| bus_rsp_valid | output | 1 | One-cycle response pulse |
| bus_rsp_rdata | output | 32 | Read data of the response |
| mem_req_valid | output | 1 | Cache request pending |
| mem_req_write | output | 1 | Cache request is a write |
| mem_req_addr | output | 41 | Backing-store byte address |
| mem_req_wdata | output | 32 | Cache write data |
| mem_req_strb | output | 4 | Cache byte strobes |
| mem_ack | input | 1 | Cache accepted/completed the request |
| mem_rdata | input | 32 | Cache read data, valid with `mem_ack` |
| flush_req | output | 1 | Flush request level to the cache |
| flush_done | input | 1 | One-cycle flush completion pulse |

## Verification
The assertions assume that the cache raises `mem_ack` only while `mem_req_valid` is high, and that `flush_done` arrives as a single-cycle pulse. They also assume that a bus request, once presented, is held until it is accepted. The bench drives the cache side from a responder that acknowledges only pending requests, after a random delay of 0 to 3 cycles. The flush completion is pulsed for exactly one cycle. Bus requests are issued one at a time from a task that keeps them stable until the handshake completes.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WIN  = 2'd1,
      ST_RESP = 2'd2
   } mpw_state_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CSR  = 2'd1,
      HIT_WIN  = 2'd2
   } mpw_hit_e;

   localparam int unsigned OFF_PAGE_SEL   = 'h000;
   localparam int unsigned OFF_FLUSH_GO   = 'h018;
   localparam int unsigned OFF_FLUSH_STAT = 'h01C;
   localparam int unsigned OFF_FLUSH_CLR  = 'h020;

endpackage

// File: rtl/mpw_decode.sv
module mpw_decode
   import mpw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12,
   parameter logic [ADDR_W-1:0] BASE = 32'hA000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output mpw_hit_e          hit,
   output logic [OFF_W-1:0]  off
);
   localparam int unsigned TAG_LO = OFF_W + 1;

   if (ADDR_W <= TAG_LO) begin : g_bad_width
      $error("mpw_decode: ADDR_W must exceed OFF_W+1");
   end

   logic in_region;

   assign in_region = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
   assign off       = addr[OFF_W-1:0];

   always_comb begin
      hit = HIT_NONE;
      if (in_region) begin
         hit = addr[OFF_W] ? HIT_WIN : HIT_CSR;
      end
   end
endmodule

// File: rtl/mpw_csr.sv
module mpw_csr
   import mpw_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEL_W  = 29,
   parameter int unsigned OFF_W  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] strb,
   input  logic                flush_done,
   output logic [SEL_W-1:0]    sel,
   output logic [DATA_W-1:0]   rdata,
   output logic                flush_req
);
   localparam int unsigned STRB_W = DATA_W / 8;

   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("mpw_csr: selector wider than data bus");
   end
   if ((DATA_W % 8) != 0) begin : g_bad_data
      $error("mpw_csr: DATA_W must be a byte multiple");
   end

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_mask;
   logic [SEL_W-1:0] sel_d;
   logic             req_q;
   logic             done_q;
   logic             hit_sel;
   logic             hit_go;
   logic             hit_stat;
   logic             hit_clr;
   logic             clr_now;

   assign hit_sel  = (off == OFF_W'(OFF_PAGE_SEL));
   assign hit_go   = (off == OFF_W'(OFF_FLUSH_GO));
   assign hit_stat = (off == OFF_W'(OFF_FLUSH_STAT));
   assign hit_clr  = (off == OFF_W'(OFF_FLUSH_CLR));

   for (genvar i = 0; i < SEL_W; i++) begin : g_mask
      assign sel_mask[i] = strb[i / 8];
   end

   if (SEL_W < DATA_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:SEL_W];
   end

   if (STRB_W * 8 > SEL_W + 8) begin : g_unused_strb
      logic unused_strb;
      assign unused_strb = ^strb[STRB_W-1:(SEL_W + 7) / 8];
   end

   assign sel_d   = (wdata[SEL_W-1:0] & sel_mask) | (sel_q & ~sel_mask);
   assign clr_now = we && hit_clr && strb[0] && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         req_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (we && hit_sel) begin
            sel_q <= sel_d;
         end
         if (req_q) begin
            req_q <= !flush_done;
         end else begin
            req_q <= we && hit_go;
         end
         done_q <= flush_done | (done_q & ~clr_now);
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_sel) begin
         rdata[SEL_W-1:0] = sel_q;
      end else if (hit_stat) begin
         rdata[0] = done_q;
      end
   end

   assign sel       = sel_q;
   assign flush_req = req_q;
endmodule

// File: rtl/mpw_winport.sv
module mpw_winport #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SEL_W      = 29,
   parameter int unsigned OFF_W      = 12,
   parameter bit          WORD_ALIGN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [SEL_W-1:0]          sel,
   input  logic [OFF_W-1:0]          off,
   input  logic                      write,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [DATA_W/8-1:0]       strb,
   input  logic                      mem_ack,
   output logic                      mem_req_valid,
   output logic                      mem_req_write,
   output logic [SEL_W+OFF_W-1:0]    mem_req_addr,
   output logic [DATA_W-1:0]         mem_req_wdata,
   output logic [DATA_W/8-1:0]       mem_req_strb
);
   localparam int unsigned BACK_W = SEL_W + OFF_W;
   localparam int unsigned LSB_W  = $clog2(DATA_W / 8);

   logic [OFF_W-1:0] off_eff;

   if (WORD_ALIGN && (LSB_W > 0)) begin : g_align
      logic unused_lsb;
      assign unused_lsb = ^off[LSB_W-1:0];
      assign off_eff    = {off[OFF_W-1:LSB_W], {LSB_W{1'b0}}};
   end else begin : g_raw
      assign off_eff = off;
   end

   logic                valid_q;
   logic                write_q;
   logic [BACK_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W/8-1:0] strb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         write_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         strb_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         write_q <= write;
         addr_q  <= {sel, off_eff};
         wdata_q <= wdata;
         strb_q  <= strb;
      end else if (valid_q && mem_ack) begin
         valid_q <= 1'b0;
      end
   end

   assign mem_req_valid = valid_q;
   assign mem_req_write = write_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;
   assign mem_req_strb  = strb_q;
endmodule

// File: rtl/mmio_page_window.sv
module mmio_page_window
   import mpw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SEL_W      = 29,
   parameter int unsigned OFF_W      = 12,
   parameter logic [31:0] BASE       = 32'hA000_0000,
   parameter bit          WORD_ALIGN = 1'b1,
   localparam int unsigned STRB_W    = DATA_W / 8,
   localparam int unsigned BACK_W    = SEL_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req_valid,
   output logic              bus_req_ready,
   input  logic              bus_req_write,
   input  logic [ADDR_W-1:0] bus_req_addr,
   input  logic [DATA_W-1:0] bus_req_wdata,
   input  logic [STRB_W-1:0] bus_req_strb,
   output logic              bus_rsp_valid,
   output logic [DATA_W-1:0] bus_rsp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [BACK_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic [STRB_W-1:0] mem_req_strb,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              flush_req,
   input  logic              flush_done
);
   if (ADDR_W != 32) begin : g_bad_addr
      $error("mmio_page_window: ADDR_W must be 32");
   end

   mpw_state_e        state_q;
   mpw_hit_e          hit;
   logic [OFF_W-1:0]  off;
   logic              accept;
   logic              csr_we;
   logic              win_load;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] csr_rdata;
   logic [DATA_W-1:0] rsp_q;

   mpw_decode #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .BASE   (BASE[ADDR_W-1:0])
   ) u_dec (
      .addr (bus_req_addr),
      .hit  (hit),
      .off  (off)
   );

   assign bus_req_ready = (state_q == ST_IDLE);
   assign accept        = bus_req_valid && bus_req_ready;
   assign csr_we        = accept && bus_req_write && (hit == HIT_CSR);
   assign win_load      = accept && (hit == HIT_WIN);

   mpw_csr #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .OFF_W  (OFF_W)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (csr_we),
      .off        (off),
      .wdata      (bus_req_wdata),
      .strb       (bus_req_strb),
      .flush_done (flush_done),
      .sel        (sel),
      .rdata      (csr_rdata),
      .flush_req  (flush_req)
   );

   mpw_winport #(
      .DATA_W     (DATA_W),
      .SEL_W      (SEL_W),
      .OFF_W      (OFF_W),
      .WORD_ALIGN (WORD_ALIGN)
   ) u_win (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (win_load),
      .sel           (sel),
      .off           (off),
      .write         (bus_req_write),
      .wdata         (bus_req_wdata),
      .strb          (bus_req_strb),
      .mem_ack       (mem_ack),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_req_strb  (mem_req_strb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rsp_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (hit == HIT_WIN) begin
                     state_q <= ST_WIN;
                  end else begin
                     state_q <= ST_RESP;
                     rsp_q   <= (bus_req_write || hit == HIT_NONE) ? '0 : csr_rdata;
                  end
               end
            end
            ST_WIN: begin
               if (mem_ack) begin
                  state_q <= ST_RESP;
                  rsp_q   <= mem_req_write ? '0 : mem_rdata;
               end
            end
            ST_RESP: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign bus_rsp_valid = (state_q == ST_RESP);
   assign bus_rsp_rdata = rsp_q;
endmodule

// File: rtl/mpw_checker.sv
module mpw_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned BACK_W = 41,
   parameter logic [31:0] BASE   = 32'hA000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req_valid,
   input logic              bus_req_ready,
   input logic [ADDR_W-1:0] bus_req_addr,
   input logic              bus_rsp_valid,
   input logic              mem_req_valid,
   input logic [BACK_W-1:0] mem_req_addr,
   input logic              mem_ack,
   input logic              flush_req,
   input logic              flush_done
);
   logic to_window;
   assign to_window = (bus_req_addr[ADDR_W-1:OFF_W+1] == BASE[ADDR_W-1:OFF_W+1])
                      && bus_req_addr[OFF_W];

   // R4: pending cache request held stable until acknowledged
   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr));

   // R4: response follows the acknowledge by one cycle
   a_r4_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_ack |=> bus_rsp_valid);

   // R5: non-window access answered in the next cycle
   a_r5_csr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_req_ready && !to_window |=> bus_rsp_valid);

   // R5: no new request accepted while a response is out
   a_r5_busy_during_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rsp_valid |-> !bus_req_ready);

   // R6: non-window access makes no cache request
   a_r6_no_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_req_ready && !to_window |=> !mem_req_valid);

   // R7: flush request held until completion
   a_r7_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req && !flush_done |=> flush_req);

   // R8: completion drops the request without a restart
   a_r8_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req && flush_done |=> !flush_req);
endmodule

bind mmio_page_window mpw_checker #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W),
   .BACK_W (BACK_W),
   .BASE   (BASE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_req_valid (bus_req_valid),
   .bus_req_ready (bus_req_ready),
   .bus_req_addr  (bus_req_addr),
   .bus_rsp_valid (bus_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_ack       (mem_ack),
   .flush_req     (flush_req),
   .flush_done    (flush_done)
);

// File: tb/sim_mmio_page_window.sv
module sim_mmio_page_window;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req_valid = 1'b0;
   logic        bus_req_ready;
   logic        bus_req_write = 1'b0;
   logic [31:0] bus_req_addr = '0;
   logic [31:0] bus_req_wdata = '0;
   logic [3:0]  bus_req_strb = '0;
   logic        bus_rsp_valid;
   logic [31:0] bus_rsp_rdata;
   logic        mem_req_valid;
   logic        mem_req_write;
   logic [40:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic [3:0]  mem_req_strb;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        flush_req;
   logic        flush_done = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mmio_page_window u0 (.*);

   // cache-side model
   logic [31:0] model [logic [40:0]];
   logic [40:0] last_addr = '0;
   int          ack_count = 0;
   int          wait_cnt = 0;

   function automatic logic [31:0] dflt(input logic [40:0] a);
      return a[31:0] ^ 32'hC3A5_0F1E;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] st);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (st[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
      end else if (mem_ack) begin
         mem_ack  = 1'b0;
         wait_cnt = $urandom % 4;
      end else if (mem_req_valid) begin
         if (wait_cnt == 0) begin
            mem_ack   = 1'b1;
            last_addr = mem_req_addr;
            ack_count++;
            if (mem_req_write) begin
               model[mem_req_addr] = merge(model.exists(mem_req_addr) ? model[mem_req_addr]
                                           : dflt(mem_req_addr), mem_req_wdata, mem_req_strb);
            end else begin
               mem_rdata = model.exists(mem_req_addr) ? model[mem_req_addr] : dflt(mem_req_addr);
            end
         end else begin
            wait_cnt--;
         end
      end
   end

   // bench-side expectation
   logic [31:0] shadow [logic [40:0]];
   logic [28:0] sel_exp = '0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus(input logic w, input logic [31:0] a, input logic [31:0] wd,
                      input logic [3:0] st, output logic [31:0] rd, output int lat);
      @(negedge clk);
      bus_req_valid = 1'b1;
      bus_req_write = w;
      bus_req_addr  = a;
      bus_req_wdata = wd;
      bus_req_strb  = st;
      while (!bus_req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_req_valid = 1'b0;
      lat = 1;
      while (!bus_rsp_valid) begin
         @(negedge clk);
         lat++;
      end
      rd = bus_rsp_rdata;
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] st);
      logic [31:0] rd;
      int lat;
      bus(1'b1, a, wd, st, rd, lat);
   endtask

   task automatic rdw(input logic [31:0] a, output logic [31:0] rd, output int lat);
      bus(1'b0, a, 32'h0, 4'hF, rd, lat);
   endtask

   localparam logic [31:0] B = 32'hA000_0000;

   initial begin
      logic [31:0] rd;
      int lat;
      int acks;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ready", bus_req_ready, 1);
      check("R1 rsp_valid", bus_rsp_valid, 0);
      check("R1 flush_req", flush_req, 0);
      rst_n = 1'b1;
      rdw(B + 32'h000, rd, lat);
      check("R1 selector", rd, 0);
      check("R5 csr latency", lat, 1);
      rdw(B + 32'h01C, rd, lat);
      check("R1 done flag", rd, 0);

      // R2 selector strobes and width
      wr(B, 32'hFFFF_FFFF, 4'hF);
      rdw(B, rd, lat);
      check("R2 full write", rd, 32'h1FFF_FFFF);
      wr(B, 32'h1234_5678, 4'b0101);
      rdw(B, rd, lat);
      check("R2 strobed write", rd, 32'h1F34_FF78);
      wr(B, 32'h0, 4'hF);
      sel_exp = '0;

      // R3 R4 window random traffic
      for (int i = 0; i < 60; i++) begin
         logic [31:0] a;
         logic [31:0] d;
         logic [3:0]  st;
         logic [40:0] ea;
         if (($urandom % 5) == 0) begin
            sel_exp = 29'($urandom);
            wr(B, {3'b000, sel_exp} | 32'hE000_0000, 4'hF);
         end
         a  = B + 32'h1000 + ($urandom % 4096);
         ea = {sel_exp, a[11:2], 2'b00};
         acks = ack_count;
         if ($urandom % 2) begin
            d  = $urandom;
            st = 4'($urandom);
            bus(1'b1, a, d, st, rd, lat);
            shadow[ea] = merge(shadow.exists(ea) ? shadow[ea] : dflt(ea), d, st);
            check("R4 write rsp data", rd, 0);
         end else begin
            rdw(a, rd, lat);
            check("R4 read data", rd, shadow.exists(ea) ? shadow[ea] : dflt(ea));
         end
         check("R3 address join", last_addr, ea);
         check("R3 one request", ack_count - acks, 1);
         check("R4 latency >= 2", lat >= 2, 1);
      end

      // R6 undefined offsets and out-of-region
      wr(B, 32'h0ABC_DEF1, 4'hF);
      wr(B + 32'h004, 32'hFFFF_FFFF, 4'hF);
      rdw(B + 32'h004, rd, lat);
      check("R6 undefined offset reads 0", rd, 0);
      rdw(B, rd, lat);
      check("R6 selector untouched", rd, 32'h0ABC_DEF1);
      acks = ack_count;
      rdw(32'hB000_1000, rd, lat);
      check("R6 outside region reads 0", rd, 0);
      check("R5 outside region latency", lat, 1);
      wr(32'h2000_1000, 32'h5555_5555, 4'hF);
      check("R6 no cache request", ack_count - acks, 0);
      rdw(B, rd, lat);
      check("R6 selector untouched 2", rd, 32'h0ABC_DEF1);

      // R7 R8 flush
      check("R7 idle", flush_req, 0);
      wr(B + 32'h018, 32'h0, 4'h0);
      check("R7 flush raised", flush_req, 1);
      wr(B + 32'h018, 32'hFFFF_FFFF, 4'hF);
      check("R8 still raised", flush_req, 1);
      rdw(B + 32'h01C, rd, lat);
      check("R9 not yet done", rd, 0);
      @(negedge clk) flush_done = 1'b1;
      @(negedge clk) flush_done = 1'b0;
      check("R7 dropped on done", flush_req, 0);
      repeat (3) @(negedge clk);
      check("R8 no restart", flush_req, 0);
      rdw(B + 32'h01C, rd, lat);
      check("R9 sticky set", rd, 1);
      rdw(B + 32'h01C, rd, lat);
      check("R9 stays set", rd, 1);

      // R10 write-1-to-clear
      wr(B + 32'h020, 32'hFFFF_FFFE, 4'hF);
      rdw(B + 32'h01C, rd, lat);
      check("R10 bit0 zero keeps flag", rd, 1);
      wr(B + 32'h020, 32'h1, 4'hE);
      rdw(B + 32'h01C, rd, lat);
      check("R10 strobe0 off keeps flag", rd, 1);
      wr(B + 32'h020, 32'h1, 4'h1);
      rdw(B + 32'h01C, rd, lat);
      check("R10 cleared", rd, 0);

      // R11 set wins over simultaneous clear
      wr(B + 32'h018, 32'h0, 4'hF);
      @(negedge clk);
      bus_req_valid = 1'b1;
      bus_req_write = 1'b1;
      bus_req_addr  = B + 32'h020;
      bus_req_wdata = 32'h1;
      bus_req_strb  = 4'hF;
      flush_done    = 1'b1;
      @(negedge clk);
      bus_req_valid = 1'b0;
      flush_done    = 1'b0;
      check("R11 response", bus_rsp_valid, 1);
      rdw(B + 32'h01C, rd, lat);
      check("R11 set wins", rd, 1);
      check("R8 flush dropped", flush_req, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule